// File: doc/BRIEF.md
# Two-Line Character Display Text Writer

This block places single characters on a 2-row by 16-column character display. The display has a controller that takes the widely used 8-bit command set over a 4-bit data bus. A client hands over a row, a column and an 8-bit character code on a valid/ready write port. The block turns the position into the controller's display-data address. Row 0 starts at 0x00 and row 1 starts at 0x40, so the map is not linear. The block then sends a set-address command followed by a data write of the character code, each byte as two nibbles with a strobed enable.

Before the first write it runs the power-on wake-up and 4-bit mode entry sequence by itself. The display's data lines are shared with the upper data bits of a parallel flash memory, so the block raises a bus request for the full length of every transfer. It drives the lines only while an external arbiter grants them. The arbiter grants once the flash is disabled or in byte-wide mode.

Columns beyond the visible range are either dropped or clamped to the last visible column, chosen by a parameter. All waits are parameters counted in clock cycles.

Top module: `lcd_text_writer`

## Requirements
- R1: After reset the block holds enable, data output-enable, bus request and write-ready low.
- R2: No enable pulse occurs earlier than T_PWRUP clock cycles after reset is released.
- R3: The first twelve nibbles, all with register-select 0, are 3, 3, 3, 2 and then the bytes 0x28, 0x06, 0x0C, 0x01, each sent upper nibble first.
- R4: Write-ready stays low until the start-up sequence is complete. It drops in the cycle after a write is accepted and stays low until all four nibbles of that write and their trailing wait are done.
- R5: A write to row r, column c (c < 16) sends command byte 0x80 + 0x40·r + c with register-select 0, then the character code with register-select 1, each upper nibble first.
- R6: With the default reject policy, a write whose column is 16 or more is accepted but causes no enable pulse, and write-ready stays high.
- R7: Enable stays high for exactly E_HIGH cycles. Data output-enable is high for at least T_SETUP cycles before enable rises and is still high in the cycle after enable falls. Data and register-select do not change while enable is high.
- R8: Between consecutive enable pulses at least T_NIB + T_SETUP cycles pass. After the clear command at least T_CLEAR cycles pass before the next pulse.
- R9: The data lines are driven only while bus request is high. A nibble starts only after grant has been seen. While grant is low no enable pulse occurs, and bus request is low whenever write-ready is high.
- R10: The read/write line is held at 0 (write) at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Block can take a write |
| wr_row | input | 1 | Target row, 0 or 1 |
| wr_col | input | COL_W | Target column |
| wr_char | input | 8 | Character code to store |
| bus_req | output | 1 | Request for the shared data lines |
| bus_gnt | input | 1 | Shared data lines granted |
| lcd_d | output | 4 | Display data nibble |
| lcd_d_oe | output | 1 | Output-enable for lcd_d |
| lcd_e | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Register select, 0 command, 1 data |
| lcd_rw | output | 1 | Read/write, held 0 |

## Verification
A corrupted step counter or sequencer state shows up at the display pins within one nibble. The scoreboard sees a nibble value or register-select that differs from the next expected entry, or sees nibbles when none are queued. A timing counter that loads the wrong value shows up at the very next enable pulse, as a wrong high width or a setup or gap shorter than configured. A wrong arbitration state shows up within a few cycles of grant being withheld, as an enable pulse while grant is low or as write-ready returning with bus request still high.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
   typedef enum logic [1:0] {SQ_PWR, SQ_INIT, SQ_IDLE, SQ_CHAR} seq_state_t;
   typedef enum logic [2:0] {TX_IDLE, TX_ARB, TX_SETUP, TX_EHI, TX_HOLD, TX_GAP} tx_state_t;

   localparam logic [3:0] NIB_WAKE    = 4'h3;
   localparam logic [3:0] NIB_4BIT    = 4'h2;
   localparam logic [7:0] CMD_FUNC    = 8'h28;
   localparam logic [7:0] CMD_ENTRY   = 8'h06;
   localparam logic [7:0] CMD_DISP    = 8'h0C;
   localparam logic [7:0] CMD_CLEAR   = 8'h01;
   localparam logic [7:0] CMD_SETADDR = 8'h80;
   localparam int         ROW_STRIDE  = 'h40;
   localparam int         LINE_LEN    = 'h28;
endpackage

// File: rtl/lcd_pos_map.sv
module lcd_pos_map
   import lcd_pkg::*;
#(
   parameter int COL_W    = 5,
   parameter int VIS_COLS = 16,
   parameter bit CLAMP    = 1'b0,
   parameter int ADDR_W   = 7
) (
   input  logic              row,
   input  logic [COL_W-1:0]  col,
   output logic [ADDR_W-1:0] addr,
   output logic              pos_ok
);
   localparam int LAST_COL = VIS_COLS - 1;
   logic [COL_W-1:0] col_eff;
   logic             in_range;

   assign in_range = (int'(col) < VIS_COLS);

   generate
      if (CLAMP) begin : g_clamp
         assign col_eff = in_range ? col : COL_W'(LAST_COL);
         assign pos_ok  = 1'b1;
      end else begin : g_reject
         assign col_eff = col;
         assign pos_ok  = in_range;
      end
   endgenerate

   assign addr = (row ? ADDR_W'(ROW_STRIDE) : '0) + ADDR_W'(col_eff);
endmodule

// File: rtl/lcd_nibble_tx.sv
module lcd_nibble_tx
   import lcd_pkg::*;
#(
   parameter int WAIT_W  = 20,
   parameter int T_SETUP = 2,
   parameter int E_HIGH  = 12,
   parameter int T_HOLD  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [3:0]        nib,
   input  logic              rs,
   input  logic [WAIT_W-1:0] wait_cyc,
   input  logic              gnt,
   output logic              done,
   output logic [3:0]        d,
   output logic              oe,
   output logic              e,
   output logic              rs_o
);
   tx_state_t         st;
   logic [WAIT_W-1:0] cnt;
   logic [WAIT_W-1:0] gap_q;
   logic [3:0]        nib_q;
   logic              rs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         cnt   <= '0;
         gap_q <= '0;
         nib_q <= '0;
         rs_q  <= 1'b0;
      end else begin
         case (st)
            TX_IDLE: if (go) begin
               nib_q <= nib;
               rs_q  <= rs;
               gap_q <= wait_cyc;
               st    <= TX_ARB;
            end
            TX_ARB: if (gnt) begin
               st  <= TX_SETUP;
               cnt <= WAIT_W'(T_SETUP - 1);
            end
            TX_SETUP: if (cnt == '0) begin
               st  <= TX_EHI;
               cnt <= WAIT_W'(E_HIGH - 1);
            end else cnt <= cnt - 1'b1;
            TX_EHI: if (cnt == '0) begin
               st  <= TX_HOLD;
               cnt <= WAIT_W'(T_HOLD - 1);
            end else cnt <= cnt - 1'b1;
            TX_HOLD: if (cnt == '0) begin
               st  <= TX_GAP;
               cnt <= gap_q - 1'b1;
            end else cnt <= cnt - 1'b1;
            TX_GAP: if (cnt == '0) st <= TX_IDLE;
                    else cnt <= cnt - 1'b1;
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign done = (st == TX_GAP) && (cnt == '0);
   assign oe   = (st == TX_SETUP) || (st == TX_EHI) || (st == TX_HOLD);
   assign e    = (st == TX_EHI);
   assign d    = oe ? nib_q : 4'h0;
   assign rs_o = rs_q;

   assert_e_inside_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      e |-> oe);
   assert_stable_during_e_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (e && $past(e)) |-> ($stable(d) && $stable(rs_o)));
   assert_drive_after_gnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(gnt));
endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
   import lcd_pkg::*;
#(
   parameter int WAIT_W  = 20,
   parameter int ADDR_W  = 7,
   parameter int T_PWRUP = 750000,
   parameter int T_INIT1 = 205000,
   parameter int T_INIT2 = 5000,
   parameter int T_INIT3 = 2000,
   parameter int T_NIB   = 50,
   parameter int T_BYTE  = 2000,
   parameter int T_CLEAR = 82000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_char,
   output logic              wr_ready,
   output logic              bus_req,
   output logic              tx_go,
   output logic [3:0]        tx_nib,
   output logic              tx_rs,
   output logic [WAIT_W-1:0] tx_wait,
   input  logic              tx_done
);
   localparam int STEP_W     = 4;
   localparam int INIT_STEPS = 12;
   localparam int CHAR_STEPS = 4;
   localparam int WAKE_STEPS = 4;

   seq_state_t        state;
   logic [STEP_W-1:0] step;
   logic [WAIT_W-1:0] pwr_cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        char_q;
   logic [7:0]        step_byte;
   logic              step_hi;
   logic [STEP_W-1:0] cmd_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_PWR;
         step    <= '0;
         pwr_cnt <= WAIT_W'(T_PWRUP - 1);
         addr_q  <= '0;
         char_q  <= '0;
      end else begin
         case (state)
            SQ_PWR: if (pwr_cnt == '0) state <= SQ_INIT;
                    else pwr_cnt <= pwr_cnt - 1'b1;
            SQ_INIT: if (tx_done) begin
               step <= step + 1'b1;
               if (step == STEP_W'(INIT_STEPS - 1)) begin
                  state <= SQ_IDLE;
                  step  <= '0;
               end
            end
            SQ_IDLE: if (wr_fire) begin
               addr_q <= wr_addr;
               char_q <= wr_char;
               state  <= SQ_CHAR;
            end
            SQ_CHAR: if (tx_done) begin
               step <= step + 1'b1;
               if (step == STEP_W'(CHAR_STEPS - 1)) begin
                  state <= SQ_IDLE;
                  step  <= '0;
               end
            end
            default: state <= SQ_PWR;
         endcase
      end
   end

   assign cmd_idx = (step - STEP_W'(WAKE_STEPS)) >> 1;

   always_comb begin
      step_byte = 8'h00;
      step_hi   = ~step[0];
      tx_rs     = 1'b0;
      tx_nib    = 4'h0;
      tx_wait   = WAIT_W'(T_BYTE);
      if (state == SQ_INIT && step < STEP_W'(WAKE_STEPS)) begin
         tx_nib = (step == STEP_W'(WAKE_STEPS - 1)) ? NIB_4BIT : NIB_WAKE;
         case (step)
            4'd0:    tx_wait = WAIT_W'(T_INIT1);
            4'd1:    tx_wait = WAIT_W'(T_INIT2);
            4'd2:    tx_wait = WAIT_W'(T_INIT3);
            default: tx_wait = WAIT_W'(T_BYTE);
         endcase
      end else begin
         if (state == SQ_INIT) begin
            case (cmd_idx)
               4'd0:    step_byte = CMD_FUNC;
               4'd1:    step_byte = CMD_ENTRY;
               4'd2:    step_byte = CMD_DISP;
               default: step_byte = CMD_CLEAR;
            endcase
         end else begin
            step_byte = step[1] ? char_q : (CMD_SETADDR | 8'(addr_q));
            tx_rs     = step[1];
         end
         tx_nib = step_hi ? step_byte[7:4] : step_byte[3:0];
         if (step_hi)
            tx_wait = WAIT_W'(T_NIB);
         else if (state == SQ_INIT && step_byte == CMD_CLEAR)
            tx_wait = WAIT_W'(T_CLEAR);
         else
            tx_wait = WAIT_W'(T_BYTE);
      end
   end

   assign tx_go    = (state == SQ_INIT) || (state == SQ_CHAR);
   assign bus_req  = tx_go;
   assign wr_ready = (state == SQ_IDLE);

   assert_done_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> bus_req);
   assert_fire_leaves_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_ready);
endmodule

// File: rtl/lcd_text_writer.sv
module lcd_text_writer
   import lcd_pkg::*;
#(
   parameter int COL_W    = 5,
   parameter int VIS_COLS = 16,
   parameter bit CLAMP    = 1'b0,
   parameter int CLK_MHZ  = 50,
   parameter int T_PWRUP  = CLK_MHZ * 15000,
   parameter int T_INIT1  = CLK_MHZ * 4100,
   parameter int T_INIT2  = CLK_MHZ * 100,
   parameter int T_INIT3  = CLK_MHZ * 40,
   parameter int T_NIB    = CLK_MHZ * 1,
   parameter int T_BYTE   = CLK_MHZ * 40,
   parameter int T_CLEAR  = CLK_MHZ * 1640,
   parameter int T_SETUP  = 2,
   parameter int E_HIGH   = 12,
   parameter int T_HOLD   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic             wr_row,
   input  logic [COL_W-1:0] wr_col,
   input  logic [7:0]       wr_char,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic [3:0]       lcd_d,
   output logic             lcd_d_oe,
   output logic             lcd_e,
   output logic             lcd_rs,
   output logic             lcd_rw
);
   localparam int ADDR_W = 7;
   localparam int WAIT_W = $clog2(T_PWRUP + 1);

   if (T_SETUP < 1 || E_HIGH < 1 || T_HOLD < 1 || T_NIB < 1 || T_BYTE < 1) begin : g_bad_timing
      $error("lcd_text_writer: every timing parameter must be at least 1");
   end
   if (T_INIT1 > T_PWRUP || T_CLEAR > T_PWRUP || T_BYTE > T_PWRUP || E_HIGH > T_PWRUP) begin : g_bad_width
      $error("lcd_text_writer: T_PWRUP must be the longest wait");
   end
   if (VIS_COLS < 1 || VIS_COLS > LINE_LEN || VIS_COLS > (1 << COL_W)) begin : g_bad_cols
      $error("lcd_text_writer: VIS_COLS out of range");
   end

   logic [ADDR_W-1:0] map_addr;
   logic              map_ok;
   logic              wr_fire;
   logic              tx_go;
   logic [3:0]        tx_nib;
   logic              tx_rs;
   logic [WAIT_W-1:0] tx_wait;
   logic              tx_done;

   lcd_pos_map #(.COL_W(COL_W), .VIS_COLS(VIS_COLS), .CLAMP(CLAMP), .ADDR_W(ADDR_W)) u_map (
      .row(wr_row), .col(wr_col), .addr(map_addr), .pos_ok(map_ok));

   assign wr_fire = wr_valid && wr_ready && map_ok;

   lcd_seq #(.WAIT_W(WAIT_W), .ADDR_W(ADDR_W), .T_PWRUP(T_PWRUP), .T_INIT1(T_INIT1),
             .T_INIT2(T_INIT2), .T_INIT3(T_INIT3), .T_NIB(T_NIB), .T_BYTE(T_BYTE),
             .T_CLEAR(T_CLEAR)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(map_addr), .wr_char(wr_char),
      .wr_ready(wr_ready), .bus_req(bus_req), .tx_go(tx_go), .tx_nib(tx_nib),
      .tx_rs(tx_rs), .tx_wait(tx_wait), .tx_done(tx_done));

   lcd_nibble_tx #(.WAIT_W(WAIT_W), .T_SETUP(T_SETUP), .E_HIGH(E_HIGH), .T_HOLD(T_HOLD)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .nib(tx_nib), .rs(tx_rs), .wait_cyc(tx_wait),
      .gnt(bus_gnt), .done(tx_done), .d(lcd_d), .oe(lcd_d_oe), .e(lcd_e), .rs_o(lcd_rs));

   assign lcd_rw = 1'b0;

   assert_oe_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_d_oe |-> bus_req);
   assert_ready_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> (!lcd_e && !lcd_d_oe));
endmodule

// File: tb/lcd_text_writer_test.sv
module lcd_text_writer_test;
   localparam int COL_W = 5, T_PWRUP = 50, T_INIT1 = 40, T_INIT2 = 20, T_INIT3 = 10;
   localparam int T_NIB = 3, T_BYTE = 8, T_CLEAR = 30, T_SETUP = 2, E_HIGH = 4, T_HOLD = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_valid = 1'b0, wr_row = 1'b0, gnt_en = 1'b1;
   logic [COL_W-1:0] wr_col = '0;
   logic [7:0] wr_char = '0;
   logic wr_ready, bus_req, bus_gnt, lcd_d_oe, lcd_e, lcd_rs, lcd_rw;
   logic [3:0] lcd_d;

   assign bus_gnt = bus_req & gnt_en;
   always #5 clk = ~clk;

   lcd_text_writer #(.COL_W(COL_W), .T_PWRUP(T_PWRUP), .T_INIT1(T_INIT1), .T_INIT2(T_INIT2),
      .T_INIT3(T_INIT3), .T_NIB(T_NIB), .T_BYTE(T_BYTE), .T_CLEAR(T_CLEAR), .T_SETUP(T_SETUP),
      .E_HIGH(E_HIGH), .T_HOLD(T_HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
      .wr_col(wr_col), .wr_char(wr_char), .bus_req(bus_req), .bus_gnt(bus_gnt), .lcd_d(lcd_d),
      .lcd_d_oe(lcd_d_oe), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw));

   int compared = 0, mismatched = 0;
   logic [4:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push_byte(input bit rs, input logic [7:0] b);
      exp_q.push_back({rs, b[7:4]});
      exp_q.push_back({rs, b[3:0]});
   endtask

   // monitor state
   int cyc = 0, nib_cnt = 0, rise_cnt = 0, first_rise = -1;
   int e_run = 0, oe_run = 0, gap_run = 0, rw_bad = 0, gnt_bad = 0;
   logic e_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) cyc++;
      if (lcd_rw) rw_bad++;
      if (lcd_d_oe && !bus_gnt) gnt_bad++;
      if (lcd_e && !e_prev) begin
         rise_cnt++;
         if (first_rise < 0) first_rise = cyc;
         chk(oe_run >= T_SETUP, "R7", "setup cycles", oe_run, T_SETUP);
         if (nib_cnt > 0) chk(gap_run >= T_NIB + T_SETUP, "R8", "nibble spacing", gap_run, T_NIB + T_SETUP);
         if (nib_cnt == 12) chk(gap_run >= T_CLEAR, "R8", "wait after clear", gap_run, T_CLEAR);
      end
      if (!lcd_e && e_prev) begin
         chk(e_run == E_HIGH, "R7", "enable width", e_run, E_HIGH);
         chk(lcd_d_oe == 1'b1, "R7", "hold after enable", lcd_d_oe, 1);
         if (exp_q.size() == 0)
            chk(1'b0, "R5", "unexpected nibble", {lcd_rs, lcd_d}, 0);
         else begin
            logic [4:0] ex;
            ex = exp_q.pop_front();
            chk({lcd_rs, lcd_d} == ex, nib_cnt < 12 ? "R3" : "R5", "nibble {rs,d}", {lcd_rs, lcd_d}, ex);
         end
         nib_cnt++;
         gap_run = 0;
      end
      e_run   = lcd_e ? e_run + 1 : 0;
      oe_run  = (lcd_d_oe && !lcd_e) ? oe_run + 1 : (lcd_e ? oe_run : 0);
      if (!lcd_e) gap_run++;
      e_prev  = lcd_e;
   end

   task automatic wait_ready;
      while (!wr_ready) @(negedge clk);
   endtask

   task automatic write_char(input bit row, input int col, input logic [7:0] ch);
      bit vis;
      vis = (col < 16);
      if (vis) begin
         push_byte(1'b0, 8'h80 | (row ? 8'h40 : 8'h00) | 8'(col));
         push_byte(1'b1, ch);
      end
      wr_valid = 1'b1; wr_row = row; wr_col = COL_W'(col); wr_char = ch;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if (vis) chk(wr_ready == 1'b0, "R4", "ready after accept", wr_ready, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int rc;
      repeat (3) @(negedge clk);
      chk(!lcd_e && !lcd_d_oe && !bus_req && !wr_ready, "R1", "reset outputs",
          {lcd_e, lcd_d_oe, bus_req, wr_ready}, 0);
      exp_q.push_back({1'b0, 4'h3}); exp_q.push_back({1'b0, 4'h3});
      exp_q.push_back({1'b0, 4'h3}); exp_q.push_back({1'b0, 4'h2});
      push_byte(1'b0, 8'h28); push_byte(1'b0, 8'h06);
      push_byte(1'b0, 8'h0C); push_byte(1'b0, 8'h01);
      rst_n = 1'b1;
      repeat (T_PWRUP + 5) @(negedge clk);
      chk(wr_ready == 1'b0, "R4", "ready during start-up", wr_ready, 0);
      wait_ready();
      chk(first_rise >= T_PWRUP, "R2", "first enable cycle", first_rise, T_PWRUP);
      chk(nib_cnt == 12, "R4", "nibbles before ready", nib_cnt, 12);
      chk(bus_req == 1'b0, "R9", "request idle after start-up", bus_req, 0);

      write_char(1'b0, 0, 8'h48);  wait_ready();
      write_char(1'b1, 15, 8'h5A); wait_ready();
      write_char(1'b1, 5, 8'hA5);  wait_ready();
      write_char(1'b0, 15, 8'h00); wait_ready();
      chk(exp_q.size() == 0, "R5", "queue drained", exp_q.size(), 0);

      rc = rise_cnt;
      write_char(1'b0, 16, 8'h41);
      chk(wr_ready == 1'b1, "R6", "ready after column 16", wr_ready, 1);
      write_char(1'b1, 20, 8'h42);
      repeat (20) @(negedge clk);
      chk(rise_cnt == rc, "R6", "pulses for hidden columns", rise_cnt - rc, 0);
      chk(bus_req == 1'b0, "R6", "no request for hidden columns", bus_req, 0);

      gnt_en = 1'b0;
      rc = rise_cnt;
      write_char(1'b0, 7, 8'h37);
      repeat (40) @(negedge clk);
      chk(rise_cnt == rc, "R9", "pulses without grant", rise_cnt - rc, 0);
      chk(bus_req == 1'b1, "R9", "request held while waiting", bus_req, 0);
      gnt_en = 1'b1;
      wait_ready();
      chk(bus_req == 1'b0, "R9", "request dropped when idle", bus_req, 0);
      chk(gnt_bad == 0, "R9", "drive without grant", gnt_bad, 0);
      chk(exp_q.size() == 0, "R5", "queue drained after stall", exp_q.size(), 0);
      chk(rw_bad == 0, "R10", "read/write line high", rw_bad, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule